// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the serial access port of a temperature sensor. An external master on a two-wire bus (SCL, SDA) writes a pointer that selects one of six 16-bit registers, then either writes a 16-bit word into that register or reads one back, most significant byte first. The block sees the bus only through a fast system clock. Both bus lines are resynchronised and edge-detected before any start, stop or data bit is recognised. It pulls SDA low through an open-drain enable and never drives it high.

The register set holds a fixed capability word, a configuration word, upper and lower alarm limits and a critical limit. It also shows the live temperature word, which together with an event status bit comes in from the sensing and event logic outside this block. The configuration word and the three limits are presented on output ports for that event logic. Two lock bits in the configuration word freeze the limit registers and the event-mode bits. Reserved bits always read as zero.

Top module: `tss_reg_slave`

## Requirements
- R1: The 7-bit bus address is binary 0011 followed by the three strap pins (strap bit 2 first). The block acknowledges an address byte only when its upper seven bits match. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: A write transfer is the address byte with the direction bit 0, then a pointer byte whose bits 2:0 select the register, then optionally an MSB byte and an LSB byte. The word is committed when the LSB byte arrives. A read transfer is the address byte with the direction bit 1. It returns the MSB and then the LSB of the register the pointer selects. The selections are 0 capability, 1 configuration, 2 upper alarm, 3 lower alarm, 4 critical and 5 temperature. Selections 6 and 7 read as 0x0000.
- R3: After reset, capability reads 0x0001, and configuration, upper alarm, lower alarm and critical all read 0x0000.
- R4: Capability and temperature are read-only. Writes to them have no effect. Temperature reads back the live temperature input.
- R5: In the configuration word, bit 4 reads the event status input and bits 15:11 read as zero. Bits 10:6 and 3:0 are writable.
- R6: The upper alarm, lower alarm and critical registers keep bits 12:2 of a written word. Bits 15:13 and 1:0 always read as zero.
- R7: While configuration bit 6 (alarm lock) is set, writes to the upper and lower alarm registers are ignored.
- R8: While configuration bit 7 (critical lock) is set, writes to the critical register are ignored.
- R9: While either lock bit is set, configuration bits 1:0 (event mode and polarity) keep their value on a configuration write. The test uses the lock state from before the write.
- R10: Once set, either lock bit stays set until reset.
- R11: Configuration bit 5 always reads 0. Writing it as 1 raises the clear-event output for exactly one clock cycle.
- R12: SDA is pulled low only during an acknowledge bit or a zero bit of read data. At all other times the enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | When high, pull SDA low (open drain) |
| strap_i | input | 3 | Low three address bits from strap pins |
| temp_i | input | 16 | Live temperature word with trip flags |
| evt_status_i | input | 1 | Event status shown in configuration bit 4 |
| cfg_o | output | 16 | Configuration word as read |
| upper_o | output | 16 | Upper alarm limit |
| lower_o | output | 16 | Lower alarm limit |
| crit_o | output | 16 | Critical limit |
| clr_evt_o | output | 1 | One-cycle clear-event pulse |

## Verification
A configuration write can change the event-mode bits and set a lock bit in the same commit. It can also set a lock and request a clear-event pulse in the same commit. The bench provokes both with single configuration words. It expects the lock to take effect only from the next write, so the mode bits still change in that word. It also expects the clear pulse to fire whether or not the word is locked. Each case is judged by the value read back over the bus and by counting pulse cycles on the clear-event output.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_WRB, S_WACK, S_RDB, S_RACK
    } bus_st_e;

    localparam logic [2:0] P_CAP  = 3'd0;
    localparam logic [2:0] P_CFG  = 3'd1;
    localparam logic [2:0] P_UP   = 3'd2;
    localparam logic [2:0] P_LO   = 3'd3;
    localparam logic [2:0] P_CRIT = 3'd4;
    localparam logic [2:0] P_TEMP = 3'd5;

    localparam logic [15:0] CFG_WMASK  = 16'h07CF;
    localparam logic [15:0] TRIP_MASK  = 16'h1FFC;
endpackage

// File: rtl/tss_pin_sync.sv
module tss_pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{s1: '1, s2: '1, s3: '1};
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign lvl_o[i]  = sync_q.s2[i];
        assign rise_o[i] = sync_q.s2[i] & ~sync_q.s3[i];
        assign fall_o[i] = ~sync_q.s2[i] & sync_q.s3[i];
    end
endmodule

// File: rtl/tss_bus_ctrl.sv
module tss_bus_ctrl
    import tss_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0011,
    parameter int         STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_lvl_i,
    input  logic               sda_rise_i,
    input  logic               sda_fall_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [15:0]        rd_word_i,
    output logic               wr_stb_o,
    output logic [1:0]         wr_idx_o,
    output logic [7:0]         wr_data_o,
    output logic               sda_oe_o
);
    localparam int CNT_W = 4;

    typedef struct packed {
        bus_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       tx;
        logic [7:0]       lsb;
        logic             rw;
        logic             mack;
        logic             oe;
        logic [1:0]       idx;
        logic             wr_stb;
        logic [1:0]       wr_idx;
        logic [7:0]       wr_data;
    } bus_t;

    bus_t bus_d, bus_q;
    logic start_c, stop_c;
    logic [6:0] my_addr;

    assign start_c = sda_fall_i & scl_lvl_i;
    assign stop_c  = sda_rise_i & scl_lvl_i;
    assign my_addr = {ADDR_HI, strap_i};

    always_comb begin
        bus_d        = bus_q;
        bus_d.wr_stb = 1'b0;
        if (start_c) begin
            bus_d.st  = S_ADDR;
            bus_d.cnt = '0;
            bus_d.oe  = 1'b0;
            bus_d.idx = 2'd0;
        end else if (stop_c) begin
            bus_d.st = S_IDLE;
            bus_d.oe = 1'b0;
        end else begin
            case (bus_q.st)
                S_ADDR, S_WRB: begin
                    if (scl_rise_i) begin
                        bus_d.sh  = {bus_q.sh[6:0], sda_lvl_i};
                        bus_d.cnt = bus_q.cnt + 1'b1;
                    end else if (scl_fall_i && bus_q.cnt == 4'd8) begin
                        if (bus_q.st == S_ADDR) begin
                            if (bus_q.sh[7:1] == my_addr) begin
                                bus_d.st = S_AACK;
                                bus_d.oe = 1'b1;
                                bus_d.rw = bus_q.sh[0];
                            end else begin
                                bus_d.st = S_IDLE;
                            end
                        end else begin
                            bus_d.st      = S_WACK;
                            bus_d.oe      = 1'b1;
                            bus_d.wr_stb  = 1'b1;
                            bus_d.wr_idx  = bus_q.idx;
                            bus_d.wr_data = bus_q.sh;
                            if (bus_q.idx != 2'd3) bus_d.idx = bus_q.idx + 1'b1;
                        end
                    end
                end
                S_AACK: begin
                    if (scl_fall_i) begin
                        bus_d.cnt = '0;
                        if (bus_q.rw) begin
                            bus_d.st  = S_RDB;
                            bus_d.tx  = rd_word_i[15:8];
                            bus_d.lsb = rd_word_i[7:0];
                            bus_d.oe  = ~rd_word_i[15];
                        end else begin
                            bus_d.st = S_WRB;
                            bus_d.oe = 1'b0;
                        end
                    end
                end
                S_WACK: begin
                    if (scl_fall_i) begin
                        bus_d.st  = S_WRB;
                        bus_d.oe  = 1'b0;
                        bus_d.cnt = '0;
                    end
                end
                S_RDB: begin
                    if (scl_rise_i) begin
                        bus_d.cnt = bus_q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (bus_q.cnt == 4'd8) begin
                            bus_d.st = S_RACK;
                            bus_d.oe = 1'b0;
                        end else begin
                            bus_d.tx = {bus_q.tx[6:0], 1'b0};
                            bus_d.oe = ~bus_q.tx[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise_i) begin
                        bus_d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (bus_q.mack) begin
                            bus_d.st  = S_RDB;
                            bus_d.cnt = '0;
                            bus_d.tx  = bus_q.lsb;
                            bus_d.lsb = 8'h00;
                            bus_d.oe  = ~bus_q.lsb[7];
                        end else begin
                            bus_d.st = S_IDLE;
                        end
                    end
                end
                default: bus_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '{st: S_IDLE, default: '0};
        else        bus_q <= bus_d;
    end

    assign wr_stb_o  = bus_q.wr_stb;
    assign wr_idx_o  = bus_q.wr_idx;
    assign wr_data_o = bus_q.wr_data;
    assign sda_oe_o  = bus_q.oe;

    // R12
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (bus_q.st != S_IDLE && bus_q.st != S_ADDR && bus_q.st != S_WRB));

    // R1
    ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q.st == S_AACK) |-> (bus_q.sh[7:1] == my_addr));
endmodule

// File: rtl/tss_reg_bank.sv
module tss_reg_bank
    import tss_pkg::*;
#(
    parameter logic [15:0] CAP_VALUE = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb_i,
    input  logic [1:0]  wr_idx_i,
    input  logic [7:0]  wr_data_i,
    input  logic [15:0] temp_i,
    input  logic        evt_status_i,
    output logic [15:0] rd_word_o,
    output logic [15:0] cfg_o,
    output logic [15:0] upper_o,
    output logic [15:0] lower_o,
    output logic [15:0] crit_o,
    output logic        clr_evt_o
);
    typedef struct packed {
        logic [2:0]  ptr;
        logic [7:0]  msb;
        logic [15:0] cfg;
        logic [15:0] up;
        logic [15:0] lo;
        logic [15:0] crit;
        logic        clr;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [15:0] word_c;
    logic        locked_c;

    assign word_c   = {bank_q.msb, wr_data_i};
    assign locked_c = bank_q.cfg[6] | bank_q.cfg[7];

    always_comb begin
        bank_d     = bank_q;
        bank_d.clr = 1'b0;
        if (wr_stb_i) begin
            case (wr_idx_i)
                2'd0: bank_d.ptr = wr_data_i[2:0];
                2'd1: bank_d.msb = wr_data_i;
                2'd2: begin
                    case (bank_q.ptr)
                        P_CFG: begin
                            bank_d.cfg = word_c & CFG_WMASK;
                            if (locked_c) bank_d.cfg[1:0] = bank_q.cfg[1:0];
                            bank_d.cfg[6] = word_c[6] | bank_q.cfg[6];
                            bank_d.cfg[7] = word_c[7] | bank_q.cfg[7];
                            bank_d.clr    = word_c[5];
                        end
                        P_UP:   if (!bank_q.cfg[6]) bank_d.up   = word_c & TRIP_MASK;
                        P_LO:   if (!bank_q.cfg[6]) bank_d.lo   = word_c & TRIP_MASK;
                        P_CRIT: if (!bank_q.cfg[7]) bank_d.crit = word_c & TRIP_MASK;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        cfg_o = bank_q.cfg | {11'd0, evt_status_i, 4'd0};
        case (bank_q.ptr)
            P_CAP:   rd_word_o = CAP_VALUE;
            P_CFG:   rd_word_o = cfg_o;
            P_UP:    rd_word_o = bank_q.up;
            P_LO:    rd_word_o = bank_q.lo;
            P_CRIT:  rd_word_o = bank_q.crit;
            P_TEMP:  rd_word_o = temp_i;
            default: rd_word_o = 16'h0000;
        endcase
    end

    assign upper_o   = bank_q.up;
    assign lower_o   = bank_q.lo;
    assign crit_o    = bank_q.crit;
    assign clr_evt_o = bank_q.clr;

    // R7
    alarm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.cfg[6] |=> ($stable(upper_o) && $stable(lower_o)));

    // R8
    crit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q.cfg[7] |=> $stable(crit_o));

    // R9
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.cfg[6] | bank_q.cfg[7]) |=> $stable(cfg_o[1:0]));

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.cfg[6] | bank_q.cfg[7]) |=> ($countones(cfg_o[7:6]) >= $countones($past(cfg_o[7:6]))));

    // R11
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt_o |=> !clr_evt_o);

    // R6
    trip_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((upper_o | lower_o | crit_o) & ~TRIP_MASK) == 16'h0000);
endmodule

// File: rtl/tss_reg_slave.sv
module tss_reg_slave
    import tss_pkg::*;
#(
    parameter logic [3:0]  ADDR_HI   = 4'b0011,
    parameter logic [15:0] CAP_VALUE = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_i,
    input  logic [15:0] temp_i,
    input  logic        evt_status_i,
    output logic [15:0] cfg_o,
    output logic [15:0] upper_o,
    output logic [15:0] lower_o,
    output logic [15:0] crit_o,
    output logic        clr_evt_o
);
    logic [1:0]  lvl, rise, fall;
    logic        wr_stb;
    logic [1:0]  wr_idx;
    logic [7:0]  wr_data;
    logic [15:0] rd_word;

    tss_pin_sync #(.W(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    tss_bus_ctrl #(.ADDR_HI(ADDR_HI), .STRAP_W(3)) i_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (lvl[0]),
        .scl_rise_i (rise[0]),
        .scl_fall_i (fall[0]),
        .sda_lvl_i  (lvl[1]),
        .sda_rise_i (rise[1]),
        .sda_fall_i (fall[1]),
        .strap_i    (strap_i),
        .rd_word_i  (rd_word),
        .wr_stb_o   (wr_stb),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .sda_oe_o   (sda_oe_o)
    );

    tss_reg_bank #(.CAP_VALUE(CAP_VALUE)) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb_i     (wr_stb),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .temp_i       (temp_i),
        .evt_status_i (evt_status_i),
        .rd_word_o    (rd_word),
        .cfg_o        (cfg_o),
        .upper_o      (upper_o),
        .lower_o      (lower_o),
        .crit_o       (crit_o),
        .clr_evt_o    (clr_evt_o)
    );
endmodule

// File: tb/test_tss_reg_slave.sv
module test_tss_reg_slave;
    localparam int Q = 25;
    localparam logic [6:0] ADDR7 = 7'h1D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [2:0] strap = 3'b101;
    logic [15:0] temp = 16'hC19A;
    logic evt = 1'b0;
    logic [15:0] cfg, up, lo, crit;
    logic clr;

    int checks = 0;
    int fails = 0;
    int clr_cnt = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];
    logic [15:0] got_q[$];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    tss_reg_slave i_tss_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .temp_i(temp), .evt_status_i(evt), .cfg_o(cfg),
        .upper_o(up), .lower_o(lo), .crit_o(crit), .clr_evt_o(clr)
    );

    always @(posedge clk) if (rst_n && clr) clr_cnt <= clr_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hq(); repeat (Q) @(negedge clk); endtask
    task automatic bstart(); sda_m = 1; hq(); scl = 1; hq(); sda_m = 0; hq(); scl = 0; hq(); endtask
    task automatic bstop(); sda_m = 0; hq(); scl = 1; hq(); sda_m = 1; hq(); hq(); endtask
    task automatic wbit(input logic b); sda_m = b; hq(); scl = 1; hq(); hq(); scl = 0; hq(); endtask
    task automatic rbit(output logic b); sda_m = 1; hq(); scl = 1; hq(); b = sda_line; hq(); scl = 0; hq(); endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) rbit(d[i]);
        wbit(~mack);
    endtask

    task automatic wr_reg(input logic [2:0] p, input logic [15:0] w);
        logic a;
        bstart();
        wbyte({ADDR7, 1'b0}, a);
        wbyte({5'd0, p}, a);
        wbyte(w[15:8], a);
        wbyte(w[7:0], a);
        bstop();
    endtask

    task automatic rd_reg(input logic [2:0] p, input logic [15:0] e, input string tag);
        logic a;
        logic [7:0] m, l;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bstart();
        wbyte({ADDR7, 1'b0}, a);
        wbyte({5'd0, p}, a);
        bstart();
        wbyte({ADDR7, 1'b1}, a);
        rbyte(m, 1'b1);
        rbyte(l, 1'b0);
        bstop();
        got_q.push_back({m, l});
    endtask

    initial begin : monitor
        logic [15:0] g, e;
        string t;
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(g == e, t, {16'd0, g}, {16'd0, e});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin : driver
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R3 reset state at the ports
        chk(cfg == 0 && up == 0 && lo == 0 && crit == 0, "R3 reset outputs",
            {cfg, up}, 0);
        chk(sda_oe == 0, "R12 idle release", {31'd0, sda_oe}, 0);
        rd_reg(3'd0, 16'h0001, "R3 capability default");
        rd_reg(3'd4, 16'h0000, "R3 critical default");

        // R1 non-matching address gets no acknowledge
        bstart();
        wbyte({7'h1C, 1'b0}, a);
        chk(a == 0, "R1 foreign address nack", {31'd0, a}, 0);
        bstop();
        chk(sda_oe == 0, "R12 release after nack", {31'd0, sda_oe}, 0);
        bstart();
        wbyte({ADDR7, 1'b0}, a);
        chk(a == 1, "R1 own address ack", {31'd0, a}, 1);
        bstop();

        // R6 reserved bits of trip registers
        wr_reg(3'd2, 16'hFFFF);
        rd_reg(3'd2, 16'h1FFC, "R6 upper reserved zero");
        wr_reg(3'd3, 16'h0123);
        rd_reg(3'd3, 16'h0120, "R6 lower masked");
        wr_reg(3'd4, 16'hE5A7);
        rd_reg(3'd4, 16'h05A4, "R6 critical masked");

        // R4 read-only registers
        wr_reg(3'd5, 16'h1234);
        rd_reg(3'd5, 16'hC19A, "R4 temperature live");
        wr_reg(3'd0, 16'hFFFF);
        rd_reg(3'd0, 16'h0001, "R4 capability read-only");
        // R2 unused pointer
        rd_reg(3'd6, 16'h0000, "R2 pointer 6 reads zero");

        // R11 clear event, R5 status bit
        wr_reg(3'd1, 16'h0023);
        chk(clr_cnt == 1, "R11 one clear pulse", clr_cnt, 1);
        rd_reg(3'd1, 16'h0003, "R11 clear bit reads zero");
        evt = 1;
        rd_reg(3'd1, 16'h0013, "R5 status bit");
        wr_reg(3'd1, 16'hF803);
        rd_reg(3'd1, 16'h0013, "R5 reserved cfg bits zero");

        // concurrent: lock set with mode change in one word
        wr_reg(3'd1, 16'h0040);
        rd_reg(3'd1, 16'h0050, "R9 mode change with lock set");
        wr_reg(3'd2, 16'h0400);
        wr_reg(3'd3, 16'h0444);
        rd_reg(3'd2, 16'h1FFC, "R7 upper frozen");
        rd_reg(3'd3, 16'h0120, "R7 lower frozen");
        wr_reg(3'd4, 16'h0200);
        rd_reg(3'd4, 16'h0200, "R8 critical open");
        wr_reg(3'd1, 16'h000F);
        rd_reg(3'd1, 16'h005C, "R9 R10 mode frozen lock sticky");
        wr_reg(3'd1, 16'h0080);
        rd_reg(3'd1, 16'h00D0, "R10 both locks");
        wr_reg(3'd4, 16'h0100);
        rd_reg(3'd4, 16'h0200, "R8 critical frozen");
        chk(crit == 16'h0200, "R8 critical port", {16'd0, crit}, 32'h0200);
        wr_reg(3'd1, 16'h0021);
        chk(clr_cnt == 2, "R11 pulse while locked", clr_cnt, 2);
        rd_reg(3'd1, 16'h00D0, "R9 locked clear write");
        chk(sda_oe == 0, "R12 final release", {31'd0, sda_oe}, 0);

        repeat (10) @(negedge clk);
        chk(got_q.size() == 0 && exp_q.size() == 0, "R2 scoreboard drained",
            got_q.size(), 0);
        finish_run();
    end
endmodule